// File: doc/BRIEF.md
# Line-Triggered Validation Window and Burst Blanking Generator

This block produces, for every incoming data line, the time window in which a downstream comparator may look for the framing code. It also produces a blanking pulse that the front end uses to reset its data slicer. All timing is counted in periods of the serial data clock. A single selected edge of the line signal starts both outputs. The window opens after a programmable delay and stays open for a fixed number of clocks. The blanking pulse starts at the edge and has its own programmable length.

A mode input can bypass the timer. In pass-through mode the synchronised line signal itself serves as the window. In both modes a monitor pin repeats the window that is in use, so its placement can be checked on a scope at any time. The line input is asynchronous to the data clock and is brought into that domain before any edge is taken from it. The block has no streaming data path. Every pin is a plain level control or status signal, so no valid/ready handshake and no back-pressure apply.

Top module: `frame_window_gen`

## Requirements
- R1: `line_in` passes through a two-flop synchroniser and then an edge detector. A qualifying change of `line_in` that is set up before clock edge k is acted on at edge k+2. Both timers therefore begin their first active cycle right after edge k+2.
- R2: When `cfg_rise_edge` is 1, only a 0-to-1 transition of the synchronised line starts a sequence. A 1-to-0 transition has no effect on either output.
- R3: When `cfg_rise_edge` is 0, only a 1-to-0 transition of the synchronised line starts a sequence. A 0-to-1 transition has no effect.
- R4: The internal window stays high for exactly 13 consecutive data-clock cycles, unless a new edge restarts it.
- R5: The internal window opens `cfg_delay` cycles (0 to 127) after the first active cycle. A delay of 0 opens it in the first active cycle itself.
- R6: When `cfg_passthru` is 1, `win_o` equals the synchronised line level (two cycles behind `line_in`, active high) and the timer has no effect on it. When `cfg_passthru` is 0, `win_o` is the internal window.
- R7: `win_mon_o` is equal to `win_o` in every cycle.
- R8: `blank_o` is high for exactly `cfg_blank_width` cycles (0 to 63), starting in the first active cycle. A width of 0 produces no pulse.
- R9: A qualifying edge that arrives while a delay, window or blanking pulse is running restarts both sequences from that edge.
- R10: While `rst_n` is low at a clock edge, the synchroniser and all counters clear. After that edge, `win_o`, `win_mon_o` and `blank_o` are 0.
- R11: `cfg_delay` and `cfg_blank_width` are captured at the starting edge. Changing them while a sequence runs does not alter that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial data clock; all timing is counted in its periods |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Asynchronous line signal |
| cfg_passthru | input | 1 | 1: synchronised line is the window; 0: internally timed window |
| cfg_rise_edge | input | 1 | 1: start on rising edge; 0: start on falling edge |
| cfg_delay | input | 7 | Window start delay in clock periods |
| cfg_blank_width | input | 6 | Blanking pulse length in clock periods |
| win_o | output | 1 | Validation window for framing-code detection |
| win_mon_o | output | 1 | Monitor copy of the window in use |
| blank_o | output | 1 | Burst blanking pulse |

## Verification
The bench builds the block with its default parameters: a 7-bit delay, a 6-bit blanking width, a 13-cycle window and a two-stage synchroniser. At these sizes the largest delay (127) and the largest width (63) each finish within a few hundred cycles. The run therefore covers both ends of every range, the delay-zero and width-zero corners, restarts in the middle of a window, and configuration changes while a sequence is running. A behavioural model counts cycles since the last qualifying edge and compares all three outputs on every clock, in both modes and across reset.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_DELAY = 2'd1,
    TMR_OPEN  = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/fwg_line_sync.sv
// Brings the asynchronous line signal into the data clock domain and
// flags the selected transition for one cycle.
module fwg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic rise_sel,
  output logic line_sync,
  output logic edge_p
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= line_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], line_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign line_sync = chain[STAGES-1];

  always_comb begin
    if (rise_sel) edge_p = line_sync & ~prev;
    else          edge_p = ~line_sync & prev;
  end
endmodule

// File: rtl/fwg_window_timer.sv
// Delay followed by a fixed-length window; a start pulse always restarts.
module fwg_window_timer
  import fwg_pkg::*;
#(
  parameter int DELAY_W = 7,
  parameter int WIN_LEN = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DELAY_W-1:0] delay,
  output logic               win
);
  localparam int WL_W  = $clog2(WIN_LEN + 1);
  localparam int CNT_W = (DELAY_W > WL_W) ? DELAY_W : WL_W;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_LEN - 1);

  tmr_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TMR_IDLE;
      cnt   <= '0;
    end else if (start) begin
      if (delay == '0) begin
        state <= TMR_OPEN;
        cnt   <= WIN_LAST;
      end else begin
        state <= TMR_DELAY;
        cnt   <= CNT_W'(delay) - ONE;
      end
    end else begin
      unique case (state)
        TMR_DELAY: begin
          if (cnt == '0) begin
            state <= TMR_OPEN;
            cnt   <= WIN_LAST;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        TMR_OPEN: begin
          if (cnt == '0) state <= TMR_IDLE;
          else           cnt   <= cnt - ONE;
        end
        default: begin
          state <= TMR_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign win = (state == TMR_OPEN);
endmodule

// File: rtl/fwg_pulse_timer.sv
// Pulse of programmable length beginning in the cycle after start.
module fwg_pulse_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] width,
  output logic         pulse
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         active;
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      left   <= '0;
    end else if (start) begin
      active <= (width != '0);
      left   <= width - ONE;
    end else if (active) begin
      if (left == '0) active <= 1'b0;
      else            left   <= left - ONE;
    end
  end

  assign pulse = active;
endmodule

// File: rtl/frame_window_gen.sv
module frame_window_gen #(
  parameter int DELAY_W     = 7,
  parameter int BLANK_W     = 6,
  parameter int WIN_LEN     = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_in,
  input  logic               cfg_passthru,
  input  logic               cfg_rise_edge,
  input  logic [DELAY_W-1:0] cfg_delay,
  input  logic [BLANK_W-1:0] cfg_blank_width,
  output logic               win_o,
  output logic               win_mon_o,
  output logic               blank_o
);
  logic line_sync;
  logic edge_p;
  logic tmr_win;

  fwg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .rise_sel  (cfg_rise_edge),
    .line_sync (line_sync),
    .edge_p    (edge_p)
  );

  fwg_window_timer #(.DELAY_W(DELAY_W), .WIN_LEN(WIN_LEN)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .start (edge_p),
    .delay (cfg_delay),
    .win   (tmr_win)
  );

  fwg_pulse_timer #(.W(BLANK_W)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .start (edge_p),
    .width (cfg_blank_width),
    .pulse (blank_o)
  );

  assign win_o     = cfg_passthru ? line_sync : tmr_win;
  assign win_mon_o = win_o;
endmodule

// File: rtl/fwg_checker.sv
module fwg_checker #(
  parameter int DELAY_W = 7,
  parameter int BLANK_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_passthru,
  input logic [DELAY_W-1:0] cfg_delay,
  input logic [BLANK_W-1:0] cfg_blank_width,
  input logic               edge_p,
  input logic               line_sync,
  input logic               tmr_win,
  input logic               win_o,
  input logic               win_mon_o,
  input logic               blank_o
);
  p_mon_mirror_r7: assert property (@(posedge clk) win_mon_o == win_o);

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (!win_o && !blank_o && !tmr_win));

  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_passthru |-> (win_o == line_sync));

  p_zero_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && cfg_delay == '0) |=> tmr_win);

  p_nonzero_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && cfg_delay != '0) |=> !tmr_win);

  p_blank_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && cfg_blank_width != '0) |=> blank_o);

  p_blank_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && cfg_blank_width == '0) |=> !blank_o);
endmodule

bind frame_window_gen fwg_checker #(.DELAY_W(DELAY_W), .BLANK_W(BLANK_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_passthru    (cfg_passthru),
  .cfg_delay       (cfg_delay),
  .cfg_blank_width (cfg_blank_width),
  .edge_p          (edge_p),
  .line_sync       (line_sync),
  .tmr_win         (tmr_win),
  .win_o           (win_o),
  .win_mon_o       (win_mon_o),
  .blank_o         (blank_o)
);

// File: tb/frame_window_gen_test.sv
module frame_window_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_in = 1'b0;
  logic       cfg_passthru = 1'b0;
  logic       cfg_rise_edge = 1'b1;
  logic [6:0] cfg_delay = '0;
  logic [5:0] cfg_blank_width = '0;
  logic       win_o, win_mon_o, blank_o;

  int    vectors = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R10";

  always #5 clk = ~clk;

  frame_window_gen uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .cfg_passthru(cfg_passthru), .cfg_rise_edge(cfg_rise_edge),
    .cfg_delay(cfg_delay), .cfg_blank_width(cfg_blank_width),
    .win_o(win_o), .win_mon_o(win_mon_o), .blank_o(blank_o)
  );

  // Behavioural reference: cycles elapsed since the last acted-on edge.
  bit m_s1, m_s2, m_s3;
  int since = -1;
  int m_dly = 0;
  int m_wid = 0;

  always @(posedge clk) begin
    bit hit;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; since = -1;
    end else begin
      hit = cfg_rise_edge ? (m_s2 && !m_s3) : (!m_s2 && m_s3);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = line_in;
      if (hit) begin
        since = 0; m_dly = cfg_delay; m_wid = cfg_blank_width;
      end else if (since >= 0 && since < 100000) begin
        since++;
      end
    end
  end

  task automatic compare();
    bit exp_tmr, exp_win, exp_blank;
    exp_tmr   = (since >= 0) && (since >= m_dly) && (since < m_dly + 13);
    exp_win   = cfg_passthru ? m_s2 : exp_tmr;
    exp_blank = (since >= 0) && (since < m_wid);
    vectors++;
    if (win_o !== exp_win) begin
      fails++;
      $display("FAIL %s win_o t=%0t actual=%b expected=%b", cur_req, $time, win_o, exp_win);
    end
    if (win_mon_o !== exp_win) begin
      fails++;
      $display("FAIL %s/R7 win_mon_o t=%0t actual=%b expected=%b", cur_req, $time, win_mon_o, exp_win);
    end
    if (blank_o !== exp_blank) begin
      fails++;
      $display("FAIL %s blank_o t=%0t actual=%b expected=%b", cur_req, $time, blank_o, exp_blank);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset with line high, outputs quiet
    cur_req = "R10"; line_in = 1'b1;
    run(4);
    rst_n = 1'b1;
    // R1/R2: the rising edge seen right after reset, delay 0, width 5
    cur_req = "R1_R2_R5_R8"; cfg_delay = 7'd0; cfg_blank_width = 6'd5;
    run(30);
    // R2: a falling transition is ignored with rising polarity
    cur_req = "R2"; line_in = 1'b0; run(25);
    // R4/R5: delay 20, width 63
    cur_req = "R4_R5"; cfg_delay = 7'd20; cfg_blank_width = 6'd63;
    line_in = 1'b1; run(90);
    // R3: falling polarity, delay 127, rising ignored
    cur_req = "R3"; cfg_rise_edge = 1'b0; cfg_delay = 7'd127; cfg_blank_width = 6'd1;
    line_in = 1'b0; run(150);
    line_in = 1'b1; run(20);
    // R8: width 0 gives no pulse
    cur_req = "R8"; cfg_delay = 7'd3; cfg_blank_width = 6'd0;
    line_in = 1'b0; run(25);
    // R9: restart mid-window with one-cycle pulses
    cur_req = "R9"; cfg_rise_edge = 1'b1; cfg_delay = 7'd2; cfg_blank_width = 6'd10;
    line_in = 1'b0; run(3);
    line_in = 1'b1; run(8);
    line_in = 1'b0; run(1);
    line_in = 1'b1; run(6);
    line_in = 1'b0; run(1);
    line_in = 1'b1; run(30);
    // R11: configuration changes during a running sequence
    cur_req = "R11"; cfg_delay = 7'd6; cfg_blank_width = 6'd9;
    line_in = 1'b0; run(2);
    line_in = 1'b1; run(4);
    cfg_delay = 7'd40; cfg_blank_width = 6'd2; run(30);
    // R6: pass-through follows the synchronised line
    cur_req = "R6"; cfg_passthru = 1'b1; cfg_delay = 7'd0; cfg_blank_width = 6'd4;
    for (int k = 0; k < 6; k++) begin
      line_in = ~line_in; run(3 + k);
    end
    cfg_passthru = 1'b0; run(20);
    // R10: reset in the middle of a window
    cur_req = "R10"; line_in = 1'b0; run(3);
    line_in = 1'b1; cfg_delay = 7'd1; cfg_blank_width = 6'd30; run(7);
    rst_n = 1'b0; run(3);
    rst_n = 1'b1; line_in = 1'b0; run(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule